// File: doc/BRIEF.md
# Battery Monitor Feature Register Controller

This block holds the one-byte control and status register of a battery monitor. The register carries two live bits. The first is a general-purpose open-drain pin bit. The second is a latch that records a low level on the power-switch pin. The block also keeps the device's active or sleep power mode, which drives the discharge-FET gate.

Software writes the register through a simple write strobe and reads it through a combinational read bus. The pin bit reads back the level sensed on the pin, not the value last written. The pin driver is forced off whenever the device is asleep or the serial bus data line has stayed low for longer than a timeout of about two seconds.

A low on the power-switch pin has two effects. It always clears the latch bit. If the device is asleep, it also wakes the device. Once cleared, the latch bit stays at zero until software writes a one to it.

Top module: `bmon_feat_reg`

## Requirements
- R1: After reset the device is active (`dfet_on`=1), the pin driver is off, and `reg_rdata` reads 8'h07 while the pin is high: bit 0 is the pin level, bit 1 is the switch latch, bit 2 is the active flag, and bits 7:3 read 0.
- R2: Writing 0 to bit 0 while no override is in force turns the pin driver on (`pio_drive_en`=1) after the write edge.
- R3: Writing 1 to bit 0 turns the pin driver off, so the pin is released.
- R4: Outside an override, bit 0 of `reg_rdata` returns the pin level seen through a two-flop synchronizer, not the written value.
- R5: When `bus_dq_in` has been low for TIMEOUT_MS worth of clock cycles, the driver turns off and bit 0 reads 1. Any high level on `bus_dq_in` restarts the count.
- R6: A `sleep_req` pulse while active enters sleep on the next edge: `dfet_on`=0, bit 2 reads 0, the driver is off, and bit 0 reads 1.
- R7: In sleep, a synchronized low on `ps_pin_in` returns the device to active mode and turns `dfet_on` back on one edge later.
- R8: While active, a low on `ps_pin_in` clears bit 1 and changes nothing else.
- R9: Once bit 1 is 0, it stays 0 until a write with bit 1 set. Writing 0 to bit 1 has no effect. After a write of 1 has rearmed the latch, a later low is captured again.
- R10: Writes to bit 0 made while sleep or the bus timeout is in force are ignored. When the override ends, the driver is still off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Register read value |
| pio_pin_in | input | 1 | Raw level of the open-drain pin |
| ps_pin_in | input | 1 | Raw level of the power-switch pin |
| bus_dq_in | input | 1 | Serial bus data-line level, already synchronous |
| sleep_req | input | 1 | Request to enter sleep mode |
| pio_drive_en | output | 1 | 1 pulls the open-drain pin to ground |
| dfet_on | output | 1 | Discharge-FET gate enable |

## Verification
A wrong mode flag shows up in the same cycle on `dfet_on` and bit 2. It also shows on the driver, because the override gates the driver combinationally. A latch bit that fails to hold or to rearm shows on bit 1 within one edge after the write or three edges after the pin falls. A bad idle counter shows as a driver that drops early or late against the exact count of low cycles. A stale synchronizer shows on bit 0 two edges after the pin moves.

// File: rtl/bmon_feat_pkg.sv
package bmon_feat_pkg;
   localparam int unsigned PIO_BIT = 0;
   localparam int unsigned PS_BIT  = 1;
   localparam int unsigned ACT_BIT = 2;
   localparam int unsigned USED_BITS = 3;

   function automatic int unsigned idle_limit(input int unsigned hz, input int unsigned ms);
      return (hz * ms) / 1000;
   endfunction
endpackage

// File: rtl/bmon_sync.sv
module bmon_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bmon_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bmon_idle_timer.sv
module bmon_idle_timer #(
   parameter int unsigned LIMIT = 65536
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic expired
);
   localparam int unsigned CW = $clog2(LIMIT + 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("bmon_idle_timer: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (line_in)              cnt <= '0;
      else if (cnt != CW'(LIMIT))    cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == CW'(LIMIT));
endmodule

// File: rtl/bmon_feat_core.sv
module bmon_feat_core (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic wd_pio,
   input  logic wd_ps,
   input  logic pio_lvl,
   input  logic ps_low,
   input  logic tmo,
   input  logic sleep_req,
   output logic drive_en,
   output logic rd_pio,
   output logic rd_ps,
   output logic active
);
   logic pio_ctl;
   logic ps_keep;
   logic override;

   assign override = !active || tmo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pio_ctl <= 1'b1;
         ps_keep <= 1'b1;
         active  <= 1'b1;
      end else begin
         if (override)  pio_ctl <= 1'b1;
         else if (we)   pio_ctl <= wd_pio;

         if (ps_low)            ps_keep <= 1'b0;
         else if (we && wd_ps)  ps_keep <= 1'b1;

         if (!active && ps_low) active <= 1'b1;
         else if (sleep_req)    active <= 1'b0;
      end
   end

   assign drive_en = !pio_ctl && !override;
   assign rd_pio   = override ? 1'b1 : pio_lvl;
   assign rd_ps    = ps_keep;
endmodule

// File: rtl/bmon_feat_reg.sv
module bmon_feat_reg #(
   parameter int unsigned REG_W       = 8,
   parameter int unsigned CLK_HZ      = 32768,
   parameter int unsigned TIMEOUT_MS  = 2000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             pio_pin_in,
   input  logic             ps_pin_in,
   input  logic             bus_dq_in,
   input  logic             sleep_req,
   output logic             pio_drive_en,
   output logic             dfet_on
);
   import bmon_feat_pkg::*;

   localparam int unsigned IDLE_LIMIT = idle_limit(CLK_HZ, TIMEOUT_MS);

   if (REG_W < USED_BITS) begin : g_bad_width
      $error("bmon_feat_reg: REG_W too small for the register fields");
   end

   logic pio_lvl;
   logic ps_lvl;
   logic ps_low;
   logic tmo_hit;
   logic rd_pio;
   logic rd_ps;
   logic act;
   logic unused_wbits;

   assign unused_wbits = ^reg_wdata;

   bmon_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pio_sync (
      .clk(clk), .rst_n(rst_n), .d(pio_pin_in), .q(pio_lvl));

   bmon_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ps_sync (
      .clk(clk), .rst_n(rst_n), .d(ps_pin_in), .q(ps_lvl));

   assign ps_low = !ps_lvl;

   bmon_idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
      .clk(clk), .rst_n(rst_n), .line_in(bus_dq_in), .expired(tmo_hit));

   bmon_feat_core u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .wd_pio   (reg_wdata[PIO_BIT]),
      .wd_ps    (reg_wdata[PS_BIT]),
      .pio_lvl  (pio_lvl),
      .ps_low   (ps_low),
      .tmo      (tmo_hit),
      .sleep_req(sleep_req),
      .drive_en (pio_drive_en),
      .rd_pio   (rd_pio),
      .rd_ps    (rd_ps),
      .active   (act)
   );

   always_comb begin
      reg_rdata          = '0;
      reg_rdata[PIO_BIT] = rd_pio;
      reg_rdata[PS_BIT]  = rd_ps;
      reg_rdata[ACT_BIT] = act;
   end

   assign dfet_on = act;
endmodule

// File: rtl/bmon_feat_chk.sv
module bmon_feat_chk #(
   parameter int unsigned REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic             wd_pio,
   input logic             wd_ps,
   input logic [REG_W-1:0] reg_rdata,
   input logic             sleep_req,
   input logic             pio_drive_en,
   input logic             dfet_on,
   input logic             tmo_hit,
   input logic             ps_low
);
   logic unused_wd;
   assign unused_wd = wd_pio;

   a_r1_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[REG_W-1:3] == '0);

   a_r5_override_drv_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!dfet_on || tmo_hit) |-> !pio_drive_en);

   a_r5_override_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!dfet_on || tmo_hit) |-> reg_rdata[0]);

   a_r6_sleep_fet_off: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_req && dfet_on) |=> !dfet_on);

   a_r7_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (!dfet_on && ps_low) |=> dfet_on);

   a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
      ps_low |=> !reg_rdata[1]);

   a_r9_ps_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rdata[1] && !(reg_we && wd_ps)) |=> !reg_rdata[1]);

   a_r10_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      ((!dfet_on || tmo_hit) && reg_we) |=> !pio_drive_en);
endmodule

bind bmon_feat_reg bmon_feat_chk #(.REG_W(REG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_we      (reg_we),
   .wd_pio      (reg_wdata[0]),
   .wd_ps       (reg_wdata[1]),
   .reg_rdata   (reg_rdata),
   .sleep_req   (sleep_req),
   .pio_drive_en(pio_drive_en),
   .dfet_on     (dfet_on),
   .tmo_hit     (tmo_hit),
   .ps_low      (ps_low)
);

// File: tb/test_bmon_feat_reg.sv
module test_bmon_feat_reg;
   localparam int CLK_PERIOD = 10;
   localparam int HZ   = 100;
   localparam int TMS  = 2000;
   localparam int LIM  = HZ * TMS / 1000;

   // {we, wdata bit0, external pin level, expected drive_en, expected read bit0}
   localparam logic [4:0] VEC [6] = '{
      5'b10110, 5'b00110, 5'b11101, 5'b00000, 5'b11000, 5'b00101 };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic pio_ext = 1'b1;
   logic pio_pin;
   logic ps_pin = 1'b1;
   logic dq = 1'b1;
   logic sleep_req = 1'b0;
   logic drv;
   logic dfet;
   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign pio_pin = drv ? 1'b0 : pio_ext;

   bmon_feat_reg #(.REG_W(8), .CLK_HZ(HZ), .TIMEOUT_MS(TMS), .SYNC_STAGES(2)) i_bmon_feat_reg (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pio_pin_in(pio_pin), .ps_pin_in(ps_pin),
      .bus_dq_in(dq), .sleep_req(sleep_req), .pio_drive_en(drv), .dfet_on(dfet));

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic ps, input logic pio);
      reg_we = 1'b1;
      reg_wdata = {6'b0, ps, pio};
      step(1);
      reg_we = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      step(2);
      rst_n = 1'b1;
      step(1);
      check("R1 rdata", reg_rdata, 8'h07);
      check("R1 drive", {7'b0, drv}, 8'h00);
      check("R1 dfet", {7'b0, dfet}, 8'h01);

      // R2 R3 R4 vector walk
      foreach (VEC[i]) begin
         pio_ext = VEC[i][2];
         if (VEC[i][4]) wr(1'b0, VEC[i][3]);
         else step(1);
         step(2);
         check("R2/R3 drive", {7'b0, drv}, {7'b0, VEC[i][1]});
         check("R4 read pin", {7'b0, reg_rdata[0]}, {7'b0, VEC[i][0]});
      end
      pio_ext = 1'b1;

      // R5 restart on a high level
      wr(1'b0, 1'b0);
      dq = 1'b0; step(LIM - 50);
      dq = 1'b1; step(1);
      dq = 1'b0; step(LIM - 50);
      check("R5 restart", {7'b0, drv}, 8'h01);
      dq = 1'b1; step(1);

      // R5 timeout exact
      dq = 1'b0; step(LIM - 1);
      check("R5 before limit", {7'b0, drv}, 8'h01);
      step(1);
      check("R5 at limit drive", {7'b0, drv}, 8'h00);
      check("R5 at limit read", {7'b0, reg_rdata[0]}, 8'h01);
      wr(1'b0, 1'b0);
      dq = 1'b1; step(1);
      check("R10 write in timeout", {7'b0, drv}, 8'h00);

      // R8 capture while active
      ps_pin = 1'b0; step(3);
      check("R8 ps bit", {7'b0, reg_rdata[1]}, 8'h00);
      check("R8 dfet", {7'b0, dfet}, 8'h01);
      check("R8 drive", {7'b0, drv}, 8'h00);
      ps_pin = 1'b1; step(3);
      check("R9 hold", {7'b0, reg_rdata[1]}, 8'h00);
      wr(1'b0, 1'b1);
      check("R9 write0 no effect", {7'b0, reg_rdata[1]}, 8'h00);
      wr(1'b1, 1'b1);
      check("R9 rearm", {7'b0, reg_rdata[1]}, 8'h01);
      ps_pin = 1'b0; step(3);
      check("R9 recapture", {7'b0, reg_rdata[1]}, 8'h00);
      ps_pin = 1'b1; step(3);
      wr(1'b1, 1'b0);
      check("R2 drive on again", {7'b0, drv}, 8'h01);

      // R6 sleep
      sleep_req = 1'b1; step(1); sleep_req = 1'b0;
      check("R6 dfet", {7'b0, dfet}, 8'h00);
      check("R6 rdata", reg_rdata, 8'h03);
      check("R6 drive", {7'b0, drv}, 8'h00);
      wr(1'b0, 1'b0);
      step(2);
      check("R10 write in sleep", {7'b0, drv}, 8'h00);

      // R7 wake
      ps_pin = 1'b0; step(2);
      check("R7 not yet", {7'b0, dfet}, 8'h00);
      step(1);
      check("R7 wake", {7'b0, dfet}, 8'h01);
      check("R7 rdata", reg_rdata, 8'h05);
      check("R10 after override", {7'b0, drv}, 8'h00);
      ps_pin = 1'b1; step(3);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule